// File: doc/BRIEF.md
# Interleaved Tridiagonal Forward-Sweep Engine

This block performs the forward elimination pass of a tridiagonal solver for several independent systems at once. Each clock it may take one matrix row: the sub-diagonal, diagonal and super-diagonal coefficients, the right-hand side, a system number and two flags that mark the first and the last row of that system. For every system it keeps the running pivot and the running right-hand side in a small context file. It emits the two scaled quantities a backward pass needs, super-diagonal over pivot and right-hand side over pivot. Both are tagged with the system number and the row index so that a downstream stack can store them.

The recurrence loop is as long as the elimination divider plus one update stage. Rows of different systems are interleaved so that each loop slot carries a different system and the engine stays busy every cycle. The two output quotients come from two dividers that run side by side, so both leave the block in the same cycle. A row whose system number repeats too soon would read stale context, so it raises a one-cycle hazard flag.

All numbers are two's-complement fixed point with two integer bits (sign included) and `FRAC` fractional bits, so the value 1.0 is the code 2^FRAC.

Top module: `tdsw_fwd_sweep`

## Requirements
- R1: While reset is held and in the cycle right after it is released, `out_vld` and `hazard_o` are 0.
- R2: On a row with `in_first`=1 the pivot is d = b and the running right-hand side is z = y, with no elimination divide. The outputs are c/d and z/d.
- R3: On a later row of the same system, l = a/d_prev, d = sat(b − ((l·c_prev) >>> FRAC)) and z = sat(y − ((l·z_prev) >>> FRAC)). The shift is arithmetic (floor) and sat clamps to the full W-bit range, W = FRAC+2. The outputs are c/d and z/d.
- R4: Every divide returns (|n|·2^FRAC)/|den|, truncated toward zero and given the sign n XOR den. A magnitude above 2^(W−1)−1 is clamped to ±(2^(W−1)−1). A zero denominator yields +(2^(W−1)−1) when n ≥ 0, otherwise −(2^(W−1)−1).
- R5: A row accepted on a clock edge appears on the outputs exactly 2·LAT cycles later. Both quotients appear in the same cycle, and a new row can be accepted every cycle.
- R6: A valid output quotient never takes the most negative code −2^(W−1).
- R7: `out_row` is 0 on a system's first row and rises by one on each further row of that system. `out_id`, `out_first` and `out_last` repeat the values the row entered with.
- R8: `hazard_o` is 1 in the cycle after a valid row whose system number matches a valid row accepted 1 to LAT cycles earlier. Otherwise it is 0.
- R9: Rows of different systems interleaved cycle by cycle, with each system's rows LAT+1 cycles apart, give the same results as each system processed alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Row present this cycle |
| in_first | input | 1 | Row is the first of its system |
| in_last | input | 1 | Row is the last of its system |
| in_id | input | IDW | System number selecting the context |
| in_a | input | W | Sub-diagonal coefficient |
| in_b | input | W | Diagonal coefficient |
| in_c | input | W | Super-diagonal coefficient |
| in_y | input | W | Right-hand side |
| out_vld | output | 1 | Output quotients valid |
| out_first | output | 1 | First-row flag of the emitted row |
| out_last | output | 1 | Last-row flag of the emitted row |
| out_id | output | IDW | System number of the emitted row |
| out_row | output | ROWW | Row index within the system |
| out_cd | output | W | Super-diagonal divided by pivot |
| out_zd | output | W | Right-hand side divided by pivot |
| hazard_o | output | 1 | System number reused within the loop window |

## Verification
Four systems are fed round-robin at exactly the loop spacing. This shows whether each context stays separate from its neighbours and whether the recurrence reads the right previous row. A single system is then fed with idle gaps, which separates the plain recurrence from the interleaving. Directed rows use a zero diagonal, an oversized quotient and a negative pivot to isolate the saturation, zero-denominator and truncation rules. A system number reused after two cycles, set against one reused after LAT+1 cycles, marks the edge of the hazard window.

// File: rtl/tdsw_pkg.sv
package tdsw_pkg;

  // Clamp a wide signed value into the range of a w-bit two's-complement word.
  function automatic logic signed [63:0] fx_sat(input logic signed [63:0] x,
                                                input int unsigned w);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -(64'sd1 <<< (w - 1));
    if (x > hi)      return hi;
    else if (x < lo) return lo;
    else             return x;
  endfunction

  // Fixed-point product, rescaled by an arithmetic (flooring) shift.
  function automatic logic signed [63:0] fx_mulsh(input logic signed [63:0] p,
                                                  input logic signed [63:0] q,
                                                  input int unsigned frac);
    return (p * q) >>> frac;
  endfunction

endpackage

// File: rtl/tdsw_div.sv
module tdsw_div #(
  parameter int unsigned W    = 16,
  parameter int unsigned FRAC = 14,
  parameter int unsigned LAT  = 3,
  parameter int unsigned TW   = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_vld,
  input  logic signed [W-1:0] in_num,
  input  logic signed [W-1:0] in_den,
  input  logic [TW-1:0]       in_tag,
  output logic                out_vld,
  output logic signed [W-1:0] out_q,
  output logic [TW-1:0]       out_tag
);
  localparam int unsigned NW = W + FRAC;
  localparam logic [W-1:0] QMAX = {1'b0, {(W-1){1'b1}}};

  // Restoring radix-2 division on magnitudes, one quotient bit per step.
  function automatic logic signed [W-1:0] rdiv(input logic signed [W-1:0] n,
                                               input logic signed [W-1:0] d);
    logic [W-1:0]  mn;
    logic [W-1:0]  md;
    logic [NW-1:0] num;
    logic [NW-1:0] q;
    logic [NW:0]   rem;
    logic [NW:0]   dx;
    logic          neg;
    mn  = n[W-1] ? W'(-n) : W'(n);
    md  = d[W-1] ? W'(-d) : W'(d);
    neg = n[W-1] ^ d[W-1];
    if (md == '0) return n[W-1] ? -$signed(QMAX) : $signed(QMAX);
    num = {mn, {FRAC{1'b0}}};
    dx  = {{(FRAC+1){1'b0}}, md};
    rem = '0;
    q   = '0;
    for (int i = int'(NW) - 1; i >= 0; i--) begin
      rem = {rem[NW-1:0], num[i]};
      if (rem >= dx) begin
        rem  = rem - dx;
        q[i] = 1'b1;
      end
    end
    if (q > NW'(QMAX)) q = NW'(QMAX);
    return neg ? -$signed(q[W-1:0]) : $signed(q[W-1:0]);
  endfunction

  logic                v_q [LAT];
  logic signed [W-1:0] q_q [LAT];
  logic [TW-1:0]       t_q [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < int'(LAT); k++) begin
        v_q[k] <= 1'b0;
        q_q[k] <= '0;
        t_q[k] <= '0;
      end
    end else begin
      v_q[0] <= in_vld;
      q_q[0] <= rdiv(in_num, in_den);
      t_q[0] <= in_tag;
      for (int k = 1; k < int'(LAT); k++) begin
        v_q[k] <= v_q[k-1];
        q_q[k] <= q_q[k-1];
        t_q[k] <= t_q[k-1];
      end
    end
  end

  assign out_vld = v_q[LAT-1];
  assign out_q   = q_q[LAT-1];
  assign out_tag = t_q[LAT-1];

endmodule

// File: rtl/tdsw_ctx.sv
module tdsw_ctx #(
  parameter int unsigned W    = 16,
  parameter int unsigned NSYS = 4,
  parameter int unsigned IDW  = 2,
  parameter int unsigned ROWW = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDW-1:0]      rd_id,
  output logic signed [W-1:0] rd_d,
  output logic signed [W-1:0] rd_c,
  output logic signed [W-1:0] rd_z,
  output logic [ROWW-1:0]     rd_row,
  input  logic                wr_en,
  input  logic [IDW-1:0]      wr_id,
  input  logic signed [W-1:0] wr_d,
  input  logic signed [W-1:0] wr_c,
  input  logic signed [W-1:0] wr_z,
  input  logic [ROWW-1:0]     wr_row
);
  logic signed [W-1:0] d_r   [NSYS];
  logic signed [W-1:0] c_r   [NSYS];
  logic signed [W-1:0] z_r   [NSYS];
  logic [ROWW-1:0]     row_r [NSYS];

  for (genvar s = 0; s < int'(NSYS); s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_r[s]   <= '0;
        c_r[s]   <= '0;
        z_r[s]   <= '0;
        row_r[s] <= '0;
      end else if (wr_en && wr_id == IDW'(s)) begin
        d_r[s]   <= wr_d;
        c_r[s]   <= wr_c;
        z_r[s]   <= wr_z;
        row_r[s] <= wr_row;
      end
    end
  end

  assign rd_d   = d_r[rd_id];
  assign rd_c   = c_r[rd_id];
  assign rd_z   = z_r[rd_id];
  assign rd_row = row_r[rd_id];

endmodule

// File: rtl/tdsw_hazard.sv
module tdsw_hazard #(
  parameter int unsigned IDW = 2,
  parameter int unsigned WIN = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_vld,
  input  logic [IDW-1:0] in_id,
  output logic           hit_o
);
  logic           hv  [WIN];
  logic [IDW-1:0] hid [WIN];
  logic [WIN-1:0] match;

  for (genvar k = 0; k < int'(WIN); k++) begin : g_cmp
    assign match[k] = hv[k] && (hid[k] == in_id);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_o <= 1'b0;
      for (int k = 0; k < int'(WIN); k++) begin
        hv[k]  <= 1'b0;
        hid[k] <= '0;
      end
    end else begin
      hit_o  <= in_vld && (|match);
      hv[0]  <= in_vld;
      hid[0] <= in_id;
      for (int k = 1; k < int'(WIN); k++) begin
        hv[k]  <= hv[k-1];
        hid[k] <= hid[k-1];
      end
    end
  end

  // R8: a hazard report always follows an accepted row.
  p_hazard_follows_row_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> $past(in_vld));

endmodule

// File: rtl/tdsw_fwd_sweep.sv
module tdsw_fwd_sweep #(
  parameter int unsigned FRAC = 14,
  parameter int unsigned LAT  = 3,
  parameter int unsigned NSYS = 4,
  parameter int unsigned ROWW = 10,
  localparam int unsigned W    = FRAC + 2,
  localparam int unsigned IDW  = (NSYS > 1) ? $clog2(NSYS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_vld,
  input  logic                in_first,
  input  logic                in_last,
  input  logic [IDW-1:0]      in_id,
  input  logic signed [W-1:0] in_a,
  input  logic signed [W-1:0] in_b,
  input  logic signed [W-1:0] in_c,
  input  logic signed [W-1:0] in_y,
  output logic                out_vld,
  output logic                out_first,
  output logic                out_last,
  output logic [IDW-1:0]      out_id,
  output logic [ROWW-1:0]     out_row,
  output logic signed [W-1:0] out_cd,
  output logic signed [W-1:0] out_zd,
  output logic                hazard_o
);
  import tdsw_pkg::*;

  localparam int unsigned LTW = 2 + IDW + 5*W + ROWW;
  localparam int unsigned QTW = 2 + IDW + ROWW;
  localparam logic signed [W-1:0] MINC = {1'b1, {(W-1){1'b0}}};

  // Context read at entry
  logic signed [W-1:0] ctx_d, ctx_c, ctx_z;
  logic [ROWW-1:0]     ctx_row;

  // Elimination divider outputs and the sideband carried with it
  logic                l_vld;
  logic signed [W-1:0] l_q;
  logic [LTW-1:0]      l_tag;
  logic                l_first, l_last;
  logic [IDW-1:0]      l_id;
  logic signed [W-1:0] l_b, l_c, l_y, l_cp, l_zp;
  logic [ROWW-1:0]     l_rp;

  // Update stage results
  logic signed [W-1:0] d_nxt, z_nxt;
  logic [ROWW-1:0]     row_nxt;

  // Recurrence register (feeds the output dividers)
  logic                rec_vld, rec_first, rec_last;
  logic [IDW-1:0]      rec_id;
  logic [ROWW-1:0]     rec_row;
  logic signed [W-1:0] rec_d, rec_c, rec_z;

  // Output divider results
  logic                cd_vld, zd_vld;
  logic signed [W-1:0] cd_q, zd_q;
  logic [QTW-1:0]      cd_tag, zd_tag;

  tdsw_ctx #(.W(W), .NSYS(NSYS), .IDW(IDW), .ROWW(ROWW)) ctx_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_id  (in_id),
    .rd_d   (ctx_d),
    .rd_c   (ctx_c),
    .rd_z   (ctx_z),
    .rd_row (ctx_row),
    .wr_en  (l_vld),
    .wr_id  (l_id),
    .wr_d   (d_nxt),
    .wr_c   (l_c),
    .wr_z   (z_nxt),
    .wr_row (row_nxt)
  );

  tdsw_hazard #(.IDW(IDW), .WIN(LAT)) haz_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_vld (in_vld),
    .in_id  (in_id),
    .hit_o  (hazard_o)
  );

  // Multiplier l = a / d_prev, with the row's other operands riding along
  tdsw_div #(.W(W), .FRAC(FRAC), .LAT(LAT), .TW(LTW)) ldiv_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .in_num  (in_a),
    .in_den  (ctx_d),
    .in_tag  ({in_first, in_last, in_id, in_b, in_c, in_y, ctx_c, ctx_z, ctx_row}),
    .out_vld (l_vld),
    .out_q   (l_q),
    .out_tag (l_tag)
  );

  assign {l_first, l_last, l_id, l_b, l_c, l_y, l_cp, l_zp, l_rp} = l_tag;

  // Pivot and right-hand-side branches are independent of each other
  always_comb begin
    logic signed [63:0] lq, bx, yx, cpx, zpx;
    lq  = l_q;
    bx  = l_b;
    yx  = l_y;
    cpx = l_cp;
    zpx = l_zp;
    if (l_first) begin
      d_nxt   = l_b;
      z_nxt   = l_y;
      row_nxt = '0;
    end else begin
      d_nxt   = W'(fx_sat(bx - fx_mulsh(lq, cpx, FRAC), W));
      z_nxt   = W'(fx_sat(yx - fx_mulsh(lq, zpx, FRAC), W));
      row_nxt = l_rp + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_vld   <= 1'b0;
      rec_first <= 1'b0;
      rec_last  <= 1'b0;
      rec_id    <= '0;
      rec_row   <= '0;
      rec_d     <= '0;
      rec_c     <= '0;
      rec_z     <= '0;
    end else begin
      rec_vld   <= l_vld;
      rec_first <= l_first;
      rec_last  <= l_last;
      rec_id    <= l_id;
      rec_row   <= row_nxt;
      rec_d     <= d_nxt;
      rec_c     <= l_c;
      rec_z     <= z_nxt;
    end
  end

  // Two quotient dividers side by side
  tdsw_div #(.W(W), .FRAC(FRAC), .LAT(LAT), .TW(QTW)) cdiv_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (rec_vld),
    .in_num  (rec_c),
    .in_den  (rec_d),
    .in_tag  ({rec_first, rec_last, rec_id, rec_row}),
    .out_vld (cd_vld),
    .out_q   (cd_q),
    .out_tag (cd_tag)
  );

  tdsw_div #(.W(W), .FRAC(FRAC), .LAT(LAT), .TW(QTW)) zdiv_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (rec_vld),
    .in_num  (rec_z),
    .in_den  (rec_d),
    .in_tag  ({rec_first, rec_last, rec_id, rec_row}),
    .out_vld (zd_vld),
    .out_q   (zd_q),
    .out_tag (zd_tag)
  );

  assign out_vld = cd_vld;
  assign {out_first, out_last, out_id, out_row} = cd_tag;
  assign out_cd  = cd_q;
  assign out_zd  = zd_q;

  // R5: the two quotient paths leave together
  p_pair_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cd_vld == zd_vld);

  // R5: both quotients belong to the same row
  p_pair_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cd_vld |-> cd_tag == zd_tag);

  // R7: a first row is always emitted as row zero
  p_first_row_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_first) |-> out_row == '0);

  // R6: clamping is symmetric, the most negative code never appears
  p_no_min_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (out_cd != MINC && out_zd != MINC));

endmodule

// File: tb/tdsw_fwd_sweep_tb.sv
module tdsw_fwd_sweep_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FRAC = 14;
  localparam int LAT  = 3;
  localparam int NSYS = 4;
  localparam int ROWW = 10;
  localparam int W    = FRAC + 2;
  localparam int IDW  = 2;
  localparam longint MAXP = (64'sd1 <<< (W - 1)) - 1;
  localparam longint MINN = -(64'sd1 <<< (W - 1));
  localparam int NV = 16;
  localparam int QD = 64;

  // id, first, last, a, b, c, y   (Q2.14: 16384 = 1.0)
  localparam int TBL [NV][7] = '{
    '{0, 1, 0,     0,  20000, -3000,  6000},
    '{1, 1, 0,     0,  18000, -2500, -4000},
    '{2, 1, 0,     0,  24000,  1200,  9000},
    '{3, 1, 0,     0, -17000,  2000,  3000},
    '{0, 0, 0, -3000,  20000, -3000,  7000},
    '{1, 0, 0, -2000,  18500, -2600, -3500},
    '{2, 0, 0,  1500,  24500,  1100,  8000},
    '{3, 0, 0,  2500, -17500,  1900, -2000},
    '{0, 0, 0, -3100,  21000, -3200, -5000},
    '{1, 0, 0, -2100,  19000, -2700, 12000},
    '{2, 0, 0,  1400,  25000,  1000, -7000},
    '{3, 0, 0,  2600, -18000,  1800,  4000},
    '{0, 0, 1, -3200,  22000,     0,  3000},
    '{1, 0, 1, -2200,  19500,     0, -1000},
    '{2, 0, 1,  1300,  25500,     0,  2500},
    '{3, 0, 1,  2700, -18500,     0, -6000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [IDW-1:0] in_id = '0;
  logic signed [W-1:0] in_a = '0, in_b = '0, in_c = '0, in_y = '0;
  logic out_vld, out_first, out_last, hazard_o;
  logic [IDW-1:0] out_id;
  logic [ROWW-1:0] out_row;
  logic signed [W-1:0] out_cd, out_zd;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdsw_fwd_sweep #(.FRAC(FRAC), .LAT(LAT), .NSYS(NSYS), .ROWW(ROWW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_first(in_first),
    .in_last(in_last), .in_id(in_id), .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .in_y(in_y), .out_vld(out_vld), .out_first(out_first), .out_last(out_last),
    .out_id(out_id), .out_row(out_row), .out_cd(out_cd), .out_zd(out_zd),
    .hazard_o(hazard_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Reference model state
  longint md [NSYS];
  longint mc [NSYS];
  longint mz [NSYS];
  int     mrow [NSYS];
  bit     hv [LAT];
  int     hid [LAT];
  int     exp_err [int];

  // Expected-output queue
  int     q_cyc [QD];
  longint q_cd [QD];
  longint q_zd [QD];
  int     q_id [QD];
  int     q_row [QD];
  bit     q_first [QD];
  bit     q_last [QD];
  string  q_tag [QD];
  int     qh = 0;
  int     qt = 0;

  task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic longint m_div(input longint n, input longint d);
    longint an, ad, q;
    if (d == 0) return (n < 0) ? -MAXP : MAXP;
    an = (n < 0) ? -n : n;
    ad = (d < 0) ? -d : d;
    q  = (an * (64'sd1 <<< FRAC)) / ad;
    if (q > MAXP) q = MAXP;
    return ((n < 0) != (d < 0)) ? -q : q;
  endfunction

  function automatic longint m_clamp(input longint x);
    if (x > MAXP) return MAXP;
    if (x < MINN) return MINN;
    return x;
  endfunction

  function automatic longint m_scale(input longint p, input longint q);
    longint prod;
    prod = p * q;
    // floor division by 2^FRAC
    if (prod >= 0) return prod / (64'sd1 <<< FRAC);
    return -((-prod + (64'sd1 <<< FRAC) - 1) / (64'sd1 <<< FRAC));
  endfunction

  task automatic push_hist(input bit v, input int id);
    for (int k = LAT - 1; k > 0; k--) begin
      hv[k]  = hv[k-1];
      hid[k] = hid[k-1];
    end
    hv[0]  = v;
    hid[0] = id;
  endtask

  task automatic idle();
    @(negedge clk);
    in_vld = 1'b0;
    push_hist(1'b0, 0);
  endtask

  task automatic drive_row(input int id, input bit first, input bit last,
                           input longint a, input longint b, input longint c,
                           input longint y, input string tag);
    longint l, d, z;
    int row;
    bit haz;
    @(negedge clk);
    if (first) begin
      d = b;
      z = y;
      row = 0;
    end else begin
      l = m_div(a, md[id]);
      d = m_clamp(b - m_scale(l, mc[id]));
      z = m_clamp(y - m_scale(l, mz[id]));
      row = mrow[id] + 1;
    end
    md[id] = d;
    mc[id] = c;
    mz[id] = z;
    mrow[id] = row;
    haz = 1'b0;
    for (int k = 0; k < LAT; k++) if (hv[k] && hid[k] == id) haz = 1'b1;
    exp_err[cyc + 1] = haz ? 1 : 0;
    q_cyc[qt % QD]   = cyc + 1 + 2*LAT;
    q_cd[qt % QD]    = m_div(c, d);
    q_zd[qt % QD]    = m_div(z, d);
    q_id[qt % QD]    = id;
    q_row[qt % QD]   = row;
    q_first[qt % QD] = first;
    q_last[qt % QD]  = last;
    q_tag[qt % QD]   = tag;
    qt++;
    push_hist(1'b1, id);
    in_vld   = 1'b1;
    in_first = first;
    in_last  = last;
    in_id    = IDW'(id);
    in_a     = W'(a);
    in_b     = W'(b);
    in_c     = W'(c);
    in_y     = W'(y);
  endtask

  // Output monitor, sampled one time unit after each rising edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (qh != qt && q_cyc[qh % QD] == cyc) begin
        chk("R5 valid at 2*LAT", out_vld == 1'b1, longint'(out_vld), 1);
        chk({q_tag[qh % QD], " c/d"}, longint'(out_cd) == q_cd[qh % QD],
            longint'(out_cd), q_cd[qh % QD]);
        chk({q_tag[qh % QD], " z/d"}, longint'(out_zd) == q_zd[qh % QD],
            longint'(out_zd), q_zd[qh % QD]);
        chk("R7 id", int'(out_id) == q_id[qh % QD], longint'(out_id), q_id[qh % QD]);
        chk("R7 row", int'(out_row) == q_row[qh % QD], longint'(out_row), q_row[qh % QD]);
        chk("R7 flags", {out_first, out_last} == {q_first[qh % QD], q_last[qh % QD]},
            longint'({out_first, out_last}), longint'({q_first[qh % QD], q_last[qh % QD]}));
        chk("R6 no min code", longint'(out_cd) != MINN && longint'(out_zd) != MINN,
            longint'(out_cd), q_cd[qh % QD]);
        qh++;
      end else if (out_vld) begin
        chk("R5 unexpected output", 1'b0, 1, 0);
      end
      if (exp_err.exists(cyc)) begin
        chk("R8 hazard", int'(hazard_o) == exp_err[cyc], longint'(hazard_o), exp_err[cyc]);
      end else if (hazard_o) begin
        chk("R8 spurious hazard", 1'b0, 1, 0);
      end
    end
  end

  initial begin
    for (int k = 0; k < LAT; k++) begin
      hv[k] = 1'b0;
      hid[k] = 0;
    end
    for (int s = 0; s < NSYS; s++) begin
      md[s] = 0; mc[s] = 0; mz[s] = 0; mrow[s] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R1 out_vld in reset", out_vld == 1'b0, longint'(out_vld), 0);
    chk("R1 hazard in reset", hazard_o == 1'b0, longint'(hazard_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_vld after reset", out_vld == 1'b0, longint'(out_vld), 0);
    chk("R1 hazard after reset", hazard_o == 1'b0, longint'(hazard_o), 0);

    // Table walk: four systems interleaved at the loop spacing
    for (int r = 0; r < NV; r++) begin
      drive_row(TBL[r][0], TBL[r][1] != 0, TBL[r][2] != 0, TBL[r][3], TBL[r][4],
                TBL[r][5], TBL[r][6], (TBL[r][1] != 0) ? "R2 first row" : "R9 interleaved");
    end
    idle();

    // One system alone with idle gaps
    drive_row(3, 1'b1, 1'b0, 0, 19000, -4000, 10000, "R2 single first");
    repeat (LAT) idle();
    drive_row(3, 1'b0, 1'b0, -5000, 19500, -4200, -9000, "R3 single later");
    repeat (LAT) idle();
    drive_row(3, 1'b0, 1'b1, 6000, 18000, 3000, 15000, "R3 single last");
    repeat (LAT) idle();

    // Division corner cases
    drive_row(0, 1'b1, 1'b1, 0, 0, 5000, -3000, "R4 zero pivot");
    drive_row(1, 1'b1, 1'b1, 0, 1000, 20000, 100, "R4 clamp");
    drive_row(2, 1'b1, 1'b1, 0, -7000, 3001, -5, "R4 truncation");
    drive_row(3, 1'b1, 1'b1, 0, 16384, -32768, 32767, "R4 extreme codes");
    repeat (LAT) idle();

    // Hazard window edges
    drive_row(0, 1'b1, 1'b1, 0, 20000, 1000, 2000, "R2 hazard pair a");
    idle();
    drive_row(0, 1'b1, 1'b1, 0, 21000, 1500, 2500, "R2 hazard pair b");
    repeat (LAT) idle();
    drive_row(1, 1'b1, 1'b0, 0, 20000, 1000, 2000, "R2 spaced a");
    repeat (LAT) idle();
    drive_row(1, 1'b0, 1'b1, 1000, 20000, 1000, 2000, "R3 spaced b");

    repeat (2*LAT + 4) idle();
    chk("R5 all outputs seen", qh == qt, longint'(qh), longint'(qt));
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule